// File: doc/BRIEF.md
# Driver Impedance Calibration Controller

This block closes the digital side of an output-driver impedance calibration loop. It drives a segment code into a replica driver leg. After each change it waits a programmable number of clocks for the analog node to settle, then reads a single comparator bit that says whether the replica still calls for at least that many segments. A start request launches a 6-bit successive-approximation search, most significant bit first. What follows the search depends on the run mode: stop there (once), repeat the full search after a programmable idle interval (periodic), or keep tracking in the background, where the code moves by one step only after three matching decisions in a row.

The calibrated code is not wired straight to the transmit drivers. An applied-code register loads only on a cycle where the update-window strobe is high, so the driver never changes partway through a transmitted symbol. A debug override can replace the calibrated value with a forced code. It is also loaded through the window. The calibration result stays visible on its own output at all times. The applied code drives both the pull-up and the pull-down segment arrays. The arrays are either thermometer coded or plain binary, chosen at build time.

Top module: `zcal_ctrl`

## Requirements
- R1: While reset is asserted, and after it until the first start, every code output is zero and both busy and done are low.
- R2: A start accepted in idle runs a search of CODE_W trials, MSB first. Each trial sets its bit on top of the bits already kept. The bit is kept when the comparator is 1 at sampling. The final code is the largest code for which a comparator defined as (replica code <= threshold) reads 1.
- R3: Each trial or probe code is held on the replica output for settle+1 clocks, and the comparator is sampled only on the last of them.
- R4: Mode encoding is 00 once, 01 periodic, 10 continuous, and 11 acts as once. On the edge that samples the last search bit, the calibration output takes the result and done goes high. In once mode busy falls on that same edge.
- R5: In periodic mode, busy stays high after a search. The block idles for period+1 clocks and then starts a new search.
- R6: In continuous mode each evaluation first probes the current code. A 0 is a down decision. On a 1 the block probes the code plus one: a 1 there is an up decision and a 0 is a hold.
- R7: The calibration code moves by exactly one only on the third consecutive identical up or down decision. A hold or a change of direction restarts the count.
- R8: Tracking saturates. At the top code a 1 on the first probe is a hold, and the code never wraps past 0 or the top.
- R9: The applied code loads only on clocks where the update-window strobe is high. Otherwise it holds.
- R10: With the override high, a window loads the debug code into the applied code while the calibration output keeps its own value.
- R11: With thermometer coding, segment bit i is 1 exactly when i < applied code (2^CODE_W-1 bits). With binary coding, the array outputs equal the applied code.
- R12: The pull-up and pull-down arrays always carry the same value.
- R13: A start while busy is ignored. An accepted start clears done on the same edge that raises busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| mode_i | input | 2 | Run mode: 00 once, 01 periodic, 10 continuous |
| settle_i | input | SETTLE_W | Extra settle clocks before each comparator sample |
| period_i | input | PER_W | Idle clocks between periodic searches (minus one) |
| cmp_i | input | 1 | Comparator: 1 means more or equal segments needed |
| upd_win_i | input | 1 | Update-window strobe for the applied code |
| dbg_ovr_i | input | 1 | Debug override enable |
| dbg_code_i | input | CODE_W | Forced debug code |
| rep_code_o | output | CODE_W | Code driven into the replica leg |
| cal_code_o | output | CODE_W | Latest calibration result |
| pu_code_o | output | DRV_W | Pull-up segment enables |
| pd_code_o | output | DRV_W | Pull-down segment enables |
| done_o | output | 1 | A search has completed since the last start |
| busy_o | output | 1 | Controller not idle |

## Verification
A wrong trial bit or settle count shows on the replica output within one settle window, and it corrupts the calibration result at the end of that search. A corrupted vote counter or direction register does not show at once. It appears as a calibration step that comes one or more evaluations early or late, or never, so the bench follows the code through the whole tracking sequence. A faulty applied-code register appears on the segment arrays in the first window-free clock after the fault, because those arrays should be frozen there.

// File: rtl/zcal_pkg.sv
package zcal_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE     = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_CONT     = 2'b10
  } cal_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SAR   = 3'd1,
    ST_PWAIT = 3'd2,
    ST_TLO   = 3'd3,
    ST_THI   = 3'd4
  } cal_state_e;

  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DOWN = 2'd2
  } trk_dec_e;

endpackage

// File: rtl/zcal_engine.sv
module zcal_engine
  import zcal_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 8,
  parameter int PER_W    = 16,
  parameter int VOTES    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [PER_W-1:0]    period_i,
  input  logic                cmp_i,
  output logic [CODE_W-1:0]   rep_code_o,
  output logic [CODE_W-1:0]   cal_code_o,
  output logic                done_o,
  output logic                busy_o
);

  localparam int BIT_W    = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam int STREAK_W = $clog2(VOTES + 1);
  localparam logic [CODE_W-1:0]   MAX_CODE = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0]   MSB_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [STREAK_W-1:0] LAST_VOTE = STREAK_W'(VOTES - 1);

  cal_state_e            state_q, state_d;
  logic [CODE_W-1:0]     rep_q, rep_d;
  logic [CODE_W-1:0]     cal_q, cal_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [SETTLE_W-1:0]   cnt_q, cnt_d;
  logic [PER_W-1:0]      pcnt_q, pcnt_d;
  trk_dec_e              dir_q, dir_d;
  logic [STREAK_W-1:0]   streak_q, streak_d;
  logic                  done_q, done_d;

  logic [CODE_W-1:0]     bit_mask;
  logic [CODE_W-1:0]     kept;
  logic                  sar_go, fin_go, trk_go;
  logic [CODE_W-1:0]     fin_code;
  trk_dec_e              trk_dec;

  assign bit_mask = {{(CODE_W-1){1'b0}}, 1'b1} << bit_q;

  always_comb begin
    state_d  = state_q;
    rep_d    = rep_q;
    cal_d    = cal_q;
    bit_d    = bit_q;
    cnt_d    = cnt_q;
    pcnt_d   = pcnt_q;
    dir_d    = dir_q;
    streak_d = streak_q;
    done_d   = done_q;
    sar_go   = 1'b0;
    fin_go   = 1'b0;
    fin_code = cal_q;
    trk_go   = 1'b0;
    trk_dec  = DEC_HOLD;
    kept     = '0;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          sar_go = 1'b1;
          done_d = 1'b0;
        end
      end
      ST_SAR: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          kept = cmp_i ? rep_q : (rep_q & ~bit_mask);
          if (bit_q == '0) begin
            cal_d    = kept;
            done_d   = 1'b1;
            fin_go   = 1'b1;
            fin_code = kept;
          end else begin
            bit_d = bit_q - 1'b1;
            rep_d = kept | (bit_mask >> 1);
            cnt_d = settle_i;
          end
        end
      end
      ST_PWAIT: begin
        if (pcnt_q != '0) begin
          pcnt_d = pcnt_q - 1'b1;
        end else if (mode_i == MODE_PERIODIC || mode_i == MODE_CONT) begin
          sar_go = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_TLO: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!cmp_i) begin
          trk_go  = 1'b1;
          trk_dec = DEC_DOWN;
        end else if (cal_q == MAX_CODE) begin
          trk_go  = 1'b1;
          trk_dec = DEC_HOLD;
        end else begin
          state_d = ST_THI;
          rep_d   = cal_q + 1'b1;
          cnt_d   = settle_i;
        end
      end
      ST_THI: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          trk_go  = 1'b1;
          trk_dec = cmp_i ? DEC_UP : DEC_HOLD;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    // vote filter: a step needs VOTES identical non-hold decisions
    if (trk_go) begin
      if (trk_dec == DEC_HOLD) begin
        streak_d = '0;
      end else if (trk_dec == dir_q && streak_q == LAST_VOTE) begin
        streak_d = '0;
        if (trk_dec == DEC_UP && cal_q != MAX_CODE) cal_d = cal_q + 1'b1;
        if (trk_dec == DEC_DOWN && cal_q != '0)     cal_d = cal_q - 1'b1;
      end else if (trk_dec == dir_q) begin
        streak_d = streak_q + 1'b1;
      end else begin
        dir_d    = trk_dec;
        streak_d = STREAK_W'(1);
      end
      fin_go   = 1'b1;
      fin_code = cal_d;
    end

    // after a search or an evaluation, the mode picks the next activity
    if (fin_go) begin
      case (cal_mode_e'(mode_i))
        MODE_CONT: begin
          state_d = ST_TLO;
          rep_d   = fin_code;
          cnt_d   = settle_i;
        end
        MODE_PERIODIC: begin
          state_d = ST_PWAIT;
          pcnt_d  = period_i;
        end
        default: state_d = ST_IDLE;
      endcase
    end

    if (sar_go) begin
      state_d  = ST_SAR;
      bit_d    = BIT_W'(CODE_W - 1);
      rep_d    = MSB_CODE;
      cnt_d    = settle_i;
      streak_d = '0;
      dir_d    = DEC_HOLD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rep_q    <= '0;
      cal_q    <= '0;
      bit_q    <= '0;
      cnt_q    <= '0;
      pcnt_q   <= '0;
      dir_q    <= DEC_HOLD;
      streak_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      rep_q    <= rep_d;
      cal_q    <= cal_d;
      bit_q    <= bit_d;
      cnt_q    <= cnt_d;
      pcnt_q   <= pcnt_d;
      dir_q    <= dir_d;
      streak_q <= streak_d;
      done_q   <= done_d;
    end
  end

  assign rep_code_o = rep_q;
  assign cal_code_o = cal_q;
  assign done_o     = done_q;
  assign busy_o     = (state_q != ST_IDLE);

  // R2: the first trial of a search is the MSB alone
  p_sar_msb_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (rep_q == MSB_CODE));

  // R3: the replica code does not move while the settle count runs
  p_settle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SAR || state_q == ST_TLO || state_q == ST_THI) && cnt_q != '0)
      |=> $stable(rep_q));

  // R7: background tracking moves the calibration code by at most one
  p_track_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TLO || state_q == ST_THI) |=>
      (cal_q == $past(cal_q) || cal_q == $past(cal_q) + 1'b1 || cal_q == $past(cal_q) - 1'b1));

  // R13: an accepted start clears done and raises busy
  p_start_clears_done_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (busy_o && !done_q));

endmodule

// File: rtl/zcal_apply.sv
module zcal_apply #(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_win_i,
  input  logic              ovr_i,
  input  logic [CODE_W-1:0] dbg_code_i,
  input  logic [CODE_W-1:0] cal_code_i,
  output logic [CODE_W-1:0] app_code_o
);

  logic [CODE_W-1:0] app_q, app_d;
  logic              app_en;

  assign app_en = upd_win_i;

  always_comb begin
    app_d = app_q;
    if (app_en) app_d = ovr_i ? dbg_code_i : cal_code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) app_q <= '0;
    else         app_q <= app_d;
  end

  assign app_code_o = app_q;

  // R9: outside an update window the driver code is frozen
  p_win_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_win_i |=> $stable(app_q));

  // R9: a window without override copies the calibration result
  p_win_cal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_win_i && !ovr_i) |=> (app_q == $past(cal_code_i)));

  // R10: a window with override loads the forced code
  p_win_ovr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_win_i && ovr_i) |=> (app_q == $past(dbg_code_i)));

endmodule

// File: rtl/zcal_seg_enc.sv
module zcal_seg_enc #(
  parameter int CODE_W = 6,
  parameter bit THERM  = 1'b1,
  parameter int OUT_W  = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [OUT_W-1:0]  seg_o
);

  if (THERM) begin : g_therm
    for (genvar g = 0; g < OUT_W; g++) begin : g_seg
      assign seg_o[g] = (code_i > CODE_W'(g));
    end
  end else begin : g_bin
    assign seg_o = code_i;
  end

endmodule

// File: rtl/zcal_ctrl.sv
module zcal_ctrl
  import zcal_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 8,
  parameter int PER_W    = 16,
  parameter int VOTES    = 3,
  parameter bit THERM    = 1'b1,
  localparam int DRV_W   = THERM ? ((1 << CODE_W) - 1) : CODE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [PER_W-1:0]    period_i,
  input  logic                cmp_i,
  input  logic                upd_win_i,
  input  logic                dbg_ovr_i,
  input  logic [CODE_W-1:0]   dbg_code_i,
  output logic [CODE_W-1:0]   rep_code_o,
  output logic [CODE_W-1:0]   cal_code_o,
  output logic [DRV_W-1:0]    pu_code_o,
  output logic [DRV_W-1:0]    pd_code_o,
  output logic                done_o,
  output logic                busy_o
);

  logic [CODE_W-1:0] cal_code;
  logic [CODE_W-1:0] app_code;
  logic [DRV_W-1:0]  seg [2];

  zcal_engine #(
    .CODE_W(CODE_W), .SETTLE_W(SETTLE_W), .PER_W(PER_W), .VOTES(VOTES)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .settle_i   (settle_i),
    .period_i   (period_i),
    .cmp_i      (cmp_i),
    .rep_code_o (rep_code_o),
    .cal_code_o (cal_code),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  zcal_apply #(.CODE_W(CODE_W)) u_apply (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_win_i  (upd_win_i),
    .ovr_i      (dbg_ovr_i),
    .dbg_code_i (dbg_code_i),
    .cal_code_i (cal_code),
    .app_code_o (app_code)
  );

  // one encoder per driver array (index 0 pull-up, 1 pull-down)
  for (genvar a = 0; a < 2; a++) begin : g_arr
    zcal_seg_enc #(.CODE_W(CODE_W), .THERM(THERM), .OUT_W(DRV_W)) u_enc (
      .code_i (app_code),
      .seg_o  (seg[a])
    );
  end

  assign cal_code_o = cal_code;
  assign pu_code_o  = seg[0];
  assign pd_code_o  = seg[1];

  // R12: both driver arrays agree
  p_pu_pd_match_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pu_code_o == pd_code_o);

  if (THERM) begin : g_chk_therm
    // R11: the number of enabled segments equals the applied code
    p_seg_count_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(pu_code_o) == int'(app_code));
  end

endmodule

// File: tb/tb_zcal_ctrl.sv
module tb_zcal_ctrl;

  localparam int CODE_W   = 6;
  localparam int SETTLE_W = 8;
  localparam int PER_W    = 16;
  localparam int DRV_W    = (1 << CODE_W) - 1;
  localparam int MAXC     = (1 << CODE_W) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [1:0]          mode = 2'b00;
  logic [SETTLE_W-1:0] settle = '0;
  logic [PER_W-1:0]    period = '0;
  logic                cmp;
  logic                win = 1'b0;
  logic                ovr = 1'b0;
  logic [CODE_W-1:0]   dbg = '0;
  logic [CODE_W-1:0]   rep, cal;
  logic [DRV_W-1:0]    pu, pd;
  logic                done, busy;
  int                  thr = 0;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  // comparator model: 1 while the replica still needs this many segments or more
  assign cmp = (int'(rep) <= thr);

  zcal_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .settle_i(settle), .period_i(period), .cmp_i(cmp), .upd_win_i(win),
    .dbg_ovr_i(ovr), .dbg_code_i(dbg), .rep_code_o(rep), .cal_code_o(cal),
    .pu_code_o(pu), .pd_code_o(pd), .done_o(done), .busy_o(busy)
  );

  // ---------------- behavioural reference model ----------------
  int m_st = 0;   // 0 idle, 1 search, 2 periodic wait, 3 probe low, 4 probe high
  int m_rep = 0, m_cal = 0, m_app = 0, m_bit = 0, m_cnt = 0, m_pcnt = 0;
  int m_dir = 0, m_streak = 0;   // dir 0 none, 1 up, 2 down
  bit m_done = 0;

  function automatic logic [63:0] therm(input int c);
    return (64'd1 << c) - 64'd1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rep = 0; m_cal = 0; m_app = 0; m_bit = 0; m_cnt = 0;
      m_pcnt = 0; m_dir = 0; m_streak = 0; m_done = 0;
    end else begin
      automatic bit c      = (m_rep <= thr);
      automatic int old_cal = m_cal;
      automatic bit launch = 0;
      automatic bit finish = 0;
      automatic int dec    = -1;
      if (win) m_app = ovr ? int'(dbg) : old_cal;
      case (m_st)
        0: if (start) begin launch = 1; m_done = 0; end
        1: if (m_cnt > 0) m_cnt--;
           else begin
             automatic int k = c ? m_rep : (m_rep & ~(1 << m_bit));
             if (m_bit == 0) begin m_cal = k; m_done = 1; finish = 1; end
             else begin m_bit--; m_rep = k | (1 << m_bit); m_cnt = settle; end
           end
        2: if (m_pcnt > 0) m_pcnt--;
           else if (mode == 2'b01 || mode == 2'b10) launch = 1;
           else m_st = 0;
        3: if (m_cnt > 0) m_cnt--;
           else if (!c) dec = 2;
           else if (m_cal == MAXC) dec = 0;
           else begin m_st = 4; m_rep = m_cal + 1; m_cnt = settle; end
        4: if (m_cnt > 0) m_cnt--;
           else dec = c ? 1 : 0;
        default: m_st = 0;
      endcase
      if (dec >= 0) begin
        if (dec == 0) m_streak = 0;
        else if (dec == m_dir) begin
          m_streak++;
          if (m_streak == 3) begin
            m_streak = 0;
            if (dec == 1 && m_cal < MAXC) m_cal++;
            if (dec == 2 && m_cal > 0)    m_cal--;
          end
        end else begin m_dir = dec; m_streak = 1; end
        finish = 1;
      end
      if (finish) begin
        if (mode == 2'b10)      begin m_st = 3; m_rep = m_cal; m_cnt = settle; end
        else if (mode == 2'b01) begin m_st = 2; m_pcnt = period; end
        else m_st = 0;
      end
      if (launch) begin
        m_st = 1; m_bit = CODE_W - 1; m_rep = 1 << (CODE_W - 1);
        m_cnt = settle; m_streak = 0; m_dir = 0;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2,R3 replica code", 64'(rep), 64'(m_rep));
      chk("R6 calibration code", 64'(cal), 64'(m_cal));
      chk("R9 pull-up array", 64'(pu), therm(m_app));
      chk("R12 pull-down array", 64'(pd), therm(m_app));
      chk("R4 done", 64'(done), 64'(m_done));
      chk("R13 busy", 64'(busy), 64'(m_st != 0));
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_win();
    @(negedge clk) win = 1'b1;
    @(negedge clk) win = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 replica at reset", 64'(rep), 0);
    chk("R1 pull-up at reset", 64'(pu), 0);
    chk("R1 busy/done at reset", 64'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 calibration after reset", 64'(cal), 0);

    // once mode, settle 2: 6 trials of 3 clocks
    settle = 8'd2; mode = 2'b00; thr = 37;
    pulse_start();
    repeat (17) @(negedge clk);
    chk("R4 done before last sample", 64'(done), 0);
    @(negedge clk);
    chk("R4 done on last sample", 64'(done), 1);
    chk("R4 busy falls in once mode", 64'(busy), 0);
    chk("R2 search result", 64'(cal), 37);
    repeat (3) @(negedge clk);
    chk("R9 no window, array held", 64'(pu), 0);
    pulse_win();
    chk("R11 thermometer of 37", 64'(pu), therm(37));
    chk("R12 pull-down equals pull-up", 64'(pd), 64'(pu));

    // R13: start clears done; a second start during the run is ignored
    pulse_start();
    chk("R13 done cleared by start", 64'(done), 0);
    repeat (4) @(negedge clk);
    thr = 63;
    pulse_start();
    wait_idle();
    chk("R2 top boundary", 64'(cal), 63);
    settle = 8'd0; thr = 0;
    pulse_start();
    wait_idle();
    chk("R2 zero boundary, settle 0", 64'(cal), 0);

    // periodic mode
    settle = 8'd1; mode = 2'b01; period = 16'd5; thr = 20;
    pulse_start();
    while (!done) @(negedge clk);
    chk("R5 first periodic result", 64'(cal), 20);
    @(negedge clk);
    chk("R5 busy during interval", 64'(busy), 1);
    thr = 25;
    repeat (40) @(negedge clk);
    chk("R5 rerun picks new threshold", 64'(cal), 25);
    mode = 2'b00;
    wait_idle();

    // continuous tracking
    settle = 8'd2; mode = 2'b10; thr = 25;
    pulse_start();
    repeat (60) @(negedge clk);
    chk("R6 hold at match", 64'(cal), 25);
    thr = 28;
    repeat (10) @(negedge clk);
    chk("R7 no step before three votes", 64'(cal), 25);
    repeat (80) @(negedge clk);
    chk("R6 tracked upward", 64'(cal), 28);
    thr = 27;
    repeat (40) @(negedge clk);
    chk("R7 single step down", 64'(cal), 27);
    pulse_start();
    chk("R13 start ignored while busy", 64'(busy), 1);

    // R10: override through the window
    ovr = 1'b1; dbg = 6'd9;
    repeat (2) @(negedge clk);
    chk("R10 no window, no override yet", 64'(pu), therm(37));
    pulse_win();
    chk("R10 override applied", 64'(pu), therm(9));
    chk("R10 calibration kept", 64'(cal), 27);
    ovr = 1'b0;
    pulse_win();
    chk("R9 window reloads calibration", 64'(pu), therm(27));

    mode = 2'b00;
    wait_idle();

    // R8: saturation at both ends
    mode = 2'b10; thr = 63;
    pulse_start();
    repeat (80) @(negedge clk);
    chk("R8 held at top code", 64'(cal), 63);
    thr = 0;
    repeat (900) @(negedge clk);
    chk("R8 floor at zero", 64'(cal), 0);
    mode = 2'b00;
    wait_idle();
    chk("R4 returns idle in once mode", 64'(busy), 0);

    if (!wd_hit) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule